// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block produces the address for each cycle of a synchronous burst memory. A cycle begins when one of two active-low address strobes fires while the chip enables select the device. The block then latches the external address and starts a four-beat burst. On later cycles with no strobe, an active-low advance input steps the two low address bits, and the upper bits stay as they were latched. The low bits follow either a linear order or an interleaved order. A burst-order input picks the order, and its value is captured when the burst starts.

The two strobes follow different rules. The processor strobe only counts while the primary enable is low, and the burst it starts is always a read. The controller strobe is always honoured, and its burst is a read or a write as the write controls decide. Each cycle is classified as deselect, begin, continue or suspend. That class, the address and a read/write flag are registered and go to the memory core on the clock edge after the command is sampled.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset puts the block in the idle state. In that state `cyc_o` = 2'b00 (deselect), `sel_o` = 0, `wr_o` = 0 and `addr_o` = 0.
- R2: A begin cycle latches `addr_i`. One clock later, `cyc_o` = 2'b01 (begin) and `addr_o` equals the `addr_i` that was sampled. A begin needs an honoured strobe, with `ce_hi` = 1 and `ce_lo_n` = 0 on that edge.
- R3: When `order_il` was 0 at the start of the burst, the low two bits on continue cycles are the start value plus 1, 2, 3 modulo 4. Continue is encoded as `cyc_o` = 2'b10.
- R4: When `order_il` was 1 at the start of the burst, the low two bits on continue cycles are the start value XOR 1, 2, 3. For example, start 01 gives 00, 11, 10.
- R5: The fourth continue after a begin returns the low bits to the loaded start value.
- R6: During continue and suspend cycles, `addr_o` bits above bit 1 stay at the loaded value.
- R7: While `ce_n` = 1, a low `proc_strb_n` is ignored. The cycle behaves as if no strobe were present.
- R8: A begin started by the processor strobe has `wr_o` = 0 whatever the write controls are. When both strobes are honoured on the same edge, the processor strobe wins.
- R9: A begin started by the controller strobe alone has `wr_o` = 1 exactly when `gw_n` = 0, or when `bw_n` = 0 with at least one bit of `byte_wr_n` low.
- R10: Three cases give a deselect (`cyc_o` = 2'b00, `wr_o` = 0): a low `ctrl_strb_n` while `ce_n` = 1, and an honoured strobe while `ce_hi` = 0 or `ce_lo_n` = 1.
- R11: With no strobe and `adv_n` = 1 during an active burst, the cycle is a suspend (`cyc_o` = 2'b11) and `addr_o` is unchanged.
- R12: With no honoured strobe while the block is deselected, the block stays deselected whatever `adv_n` is.
- R13: A new begin in the middle of a burst restarts the four-beat sequence from the new address, with no idle cycle.
- R14: On continue and suspend cycles, `wr_o` follows the write controls sampled on that edge, using the same rule as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | External start address |
| proc_strb_n | input | 1 | Processor address strobe, active low, masked by `ce_n` |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Secondary enable, must be high on a strobe |
| ce_lo_n | input | 1 | Secondary enable, must be low on a strobe |
| gw_n | input | 1 | Write-all control, active low |
| bw_n | input | 1 | Byte-write qualifier, active low |
| byte_wr_n | input | NUM_BYTES | Per-byte write selects, active low |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr_o | output | ADDR_W | Address of the current cycle |
| cyc_o | output | 2 | Cycle type: 00 deselect, 01 begin, 10 continue, 11 suspend |
| sel_o | output | 1 | High when the current cycle is not a deselect |
| wr_o | output | 1 | High for a write cycle |

## Verification
A wrong beat counter or a wrong latched burst order shows as a wrong low address pair on the very next continue cycle. The wrap fault needs four continues before it can be seen. A wrong selected/idle flag only becomes visible on the next cycle without a strobe: a dead burst then reports continue, or a live one reports deselect. The stimulus therefore mixes stretches with no strobe into the random traffic. Strobe masking faults and forced-read faults appear on `cyc_o` and `wr_o` one clock after the offending edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BURST_BITS = 2;

    typedef enum logic [1:0] {
        CYC_DESEL = 2'b00,
        CYC_BEGIN = 2'b01,
        CYC_CONT  = 2'b10,
        CYC_SUSP  = 2'b11
    } cyc_e;

    typedef struct packed {
        cyc_e cyc;
        logic wr;
        logic load;
        logic step;
    } cmd_t;

    // low address bits for a given beat of a burst
    function automatic logic [BURST_BITS-1:0] beat_low(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] beat,
        input logic                  interleave
    );
        if (interleave)
            return start ^ beat;
        else
            return start + beat;
    endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_pkg::*;
#(
    parameter int NUM_BYTES = 8
) (
    input  logic                 proc_strb_n,
    input  logic                 ctrl_strb_n,
    input  logic                 adv_n,
    input  logic                 ce_n,
    input  logic                 ce_hi,
    input  logic                 ce_lo_n,
    input  logic                 gw_n,
    input  logic                 bw_n,
    input  logic [NUM_BYTES-1:0] byte_wr_n,
    input  logic                 active,
    output cmd_t                 cmd
);

    logic proc_hit;
    logic ctrl_hit;
    logic sec_ok;
    logic wr_req;

    assign proc_hit = !proc_strb_n && !ce_n;
    assign ctrl_hit = !ctrl_strb_n;
    assign sec_ok   = ce_hi && !ce_lo_n;
    assign wr_req   = !gw_n || (!bw_n && !(&byte_wr_n));

    always_comb begin
        cmd.cyc  = CYC_DESEL;
        cmd.wr   = 1'b0;
        cmd.load = 1'b0;
        cmd.step = 1'b0;
        if (ctrl_hit && ce_n) begin
            cmd.cyc = CYC_DESEL;
        end else if (proc_hit || ctrl_hit) begin
            if (sec_ok) begin
                cmd.cyc  = CYC_BEGIN;
                cmd.load = 1'b1;
                cmd.wr   = proc_hit ? 1'b0 : wr_req;
            end
        end else if (active) begin
            cmd.wr = wr_req;
            if (!adv_n) begin
                cmd.cyc  = CYC_CONT;
                cmd.step = 1'b1;
            end else begin
                cmd.cyc = CYC_SUSP;
            end
        end
    end

endmodule

// File: rtl/burst_seq_counter.sv
module burst_seq_counter
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UPPER_W = ADDR_W - BURST_BITS;

    logic [ADDR_W-1:0]     base_q;
    logic [BURST_BITS-1:0] beat_q;
    logic                  il_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
            il_q   <= 1'b0;
        end else if (load) begin
            base_q <= addr_i;
            beat_q <= '0;
            il_q   <= order_il;
        end else if (step) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign addr_o = {base_q[ADDR_W-1 -: UPPER_W],
                     beat_low(base_q[BURST_BITS-1:0], beat_q, il_q)};

    // a continue from the last beat lands back on the start value
    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !load && beat_q == {BURST_BITS{1'b1}})
            |=> addr_o[BURST_BITS-1:0] == base_q[BURST_BITS-1:0]);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int NUM_BYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 proc_strb_n,
    input  logic                 ctrl_strb_n,
    input  logic                 adv_n,
    input  logic                 ce_n,
    input  logic                 ce_hi,
    input  logic                 ce_lo_n,
    input  logic                 gw_n,
    input  logic                 bw_n,
    input  logic [NUM_BYTES-1:0] byte_wr_n,
    input  logic                 order_il,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [1:0]           cyc_o,
    output logic                 sel_o,
    output logic                 wr_o
);

    cmd_t cmd;
    cyc_e cyc_q;
    logic wr_q;
    logic active;

    assign active = (cyc_q != CYC_DESEL);

    burst_cmd_decode #(.NUM_BYTES(NUM_BYTES)) u_decode (
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .adv_n       (adv_n),
        .ce_n        (ce_n),
        .ce_hi       (ce_hi),
        .ce_lo_n     (ce_lo_n),
        .gw_n        (gw_n),
        .bw_n        (bw_n),
        .byte_wr_n   (byte_wr_n),
        .active      (active),
        .cmd         (cmd)
    );

    burst_seq_counter #(.ADDR_W(ADDR_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd.load),
        .step     (cmd.step),
        .order_il (order_il),
        .addr_i   (addr_i),
        .addr_o   (addr_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= CYC_DESEL;
            wr_q  <= 1'b0;
        end else begin
            cyc_q <= cmd.cyc;
            wr_q  <= cmd.wr;
        end
    end

    assign cyc_o = cyc_q;
    assign sel_o = active;
    assign wr_o  = wr_q;

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && (!proc_strb_n || !ctrl_strb_n) && ce_hi && !ce_lo_n)
            |=> (cyc_o == 2'b01) && (addr_o == $past(addr_i)));

    assert_upper_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cyc_o == 2'b10 || cyc_o == 2'b11)
            |-> addr_o[ADDR_W-1:BURST_BITS] == $past(addr_o[ADDR_W-1:BURST_BITS]));

    assert_proc_read_R8: assert property (@(posedge clk) disable iff (rst)
        (!proc_strb_n && !ce_n && ce_hi && !ce_lo_n) |=> !wr_o);

    assert_ctrl_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_strb_n && ce_n) |=> (cyc_o == 2'b00) && !wr_o);

    assert_suspend_R11: assert property (@(posedge clk) disable iff (rst)
        (cyc_o == 2'b11) |-> $stable(addr_o));

    assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (!sel_o && ctrl_strb_n && (proc_strb_n || ce_n)) |=> !sel_o);

endmodule

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;

    localparam int AW = 20;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_i;
    logic          proc_strb_n, ctrl_strb_n, adv_n, ce_n, ce_hi, ce_lo_n;
    logic          gw_n, bw_n, order_il;
    logic [NB-1:0] byte_wr_n;
    logic [AW-1:0] addr_o;
    logic [1:0]    cyc_o;
    logic          sel_o, wr_o;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    // reference state
    logic [AW-1:0] m_base;
    logic [1:0]    m_beat;
    logic          m_il;
    logic [1:0]    m_cyc;
    logic          m_wr;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .NUM_BYTES(NB)) u_burst_addr_gen (
        .clk(clk), .rst(rst), .addr_i(addr_i),
        .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
        .ce_n(ce_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
        .gw_n(gw_n), .bw_n(bw_n), .byte_wr_n(byte_wr_n), .order_il(order_il),
        .addr_o(addr_o), .cyc_o(cyc_o), .sel_o(sel_o), .wr_o(wr_o)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = m_il ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic wr_rule();
        return !gw_n || (!bw_n && (byte_wr_n != '1));
    endfunction

    task automatic model_edge();
        logic p_hit, c_hit, sec;
        if (rst) begin
            m_base = '0; m_beat = '0; m_il = 1'b0; m_cyc = 2'b00; m_wr = 1'b0;
            return;
        end
        p_hit = !proc_strb_n && !ce_n;
        c_hit = !ctrl_strb_n;
        sec   = ce_hi && !ce_lo_n;
        if (c_hit && ce_n) begin
            m_cyc = 2'b00; m_wr = 1'b0;
        end else if (p_hit || c_hit) begin
            if (sec) begin
                m_cyc = 2'b01; m_base = addr_i; m_beat = 2'b00; m_il = order_il;
                m_wr = p_hit ? 1'b0 : wr_rule();
            end else begin
                m_cyc = 2'b00; m_wr = 1'b0;
            end
        end else if (m_cyc != 2'b00) begin
            m_wr = wr_rule();
            if (!adv_n) begin m_cyc = 2'b10; m_beat = m_beat + 2'b01; end
            else m_cyc = 2'b11;
        end else begin
            m_cyc = 2'b00; m_wr = 1'b0;
        end
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one clock: sample inputs at posedge, compare at following negedge
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "cyc_o", AW'(cyc_o), AW'(m_cyc));
        chk(tag, "addr_o", addr_o, exp_addr());
        chk(tag, "wr_o", AW'(wr_o), AW'(m_wr));
        chk(tag, "sel_o", AW'(sel_o), AW'(m_cyc != 2'b00));
    endtask

    task automatic idle_in();
        proc_strb_n = 1; ctrl_strb_n = 1; adv_n = 1; ce_n = 0; ce_hi = 1; ce_lo_n = 0;
        gw_n = 1; bw_n = 1; byte_wr_n = '1;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            summary();
        end
    end

    initial begin
        logic [1:0] start_lo;
        idle_in(); addr_i = '0; order_il = 0; rst = 1;
        @(negedge clk);
        step("R1"); step("R1");
        chk("R1", "reset cyc_o", AW'(cyc_o), 0);
        chk("R1", "reset addr_o", addr_o, 0);
        rst = 0;

        // processor begin, interleaved, start 01, write controls active
        proc_strb_n = 0; addr_i = 20'hABC01; order_il = 1; gw_n = 0;
        step("R8");
        chk("R2", "begin addr", addr_o, 20'hABC01);
        chk("R8", "forced read", AW'(wr_o), 0);
        proc_strb_n = 1; gw_n = 1; adv_n = 0; order_il = 0;
        step("R4"); chk("R4", "il beat1", AW'(addr_o[1:0]), 0);
        step("R4"); chk("R4", "il beat2", AW'(addr_o[1:0]), 3);
        step("R4"); chk("R4", "il beat3", AW'(addr_o[1:0]), 2);
        step("R5"); chk("R5", "wrap", addr_o, 20'hABC01);
        chk("R6", "upper held", AW'(addr_o[AW-1:2]), AW'(20'hABC01 >> 2));

        // controller begin, linear, start 10, byte write
        ctrl_strb_n = 0; addr_i = 20'h12342; bw_n = 0; byte_wr_n = 8'hF7; adv_n = 1;
        step("R9"); chk("R9", "ctrl write", AW'(wr_o), 1);
        ctrl_strb_n = 1; adv_n = 0;
        step("R3"); chk("R3", "lin beat1", AW'(addr_o[1:0]), 3);
        step("R3"); chk("R3", "lin beat2", AW'(addr_o[1:0]), 0);
        adv_n = 1;
        step("R11"); chk("R11", "suspend", AW'(addr_o[1:0]), 0);
        chk("R11", "suspend cyc", AW'(cyc_o), 3);
        bw_n = 1; adv_n = 0;
        step("R14"); chk("R14", "cont read", AW'(wr_o), 0);
        chk("R3", "lin beat3", AW'(addr_o[1:0]), 1);

        // processor strobe masked by primary enable
        ce_n = 1; proc_strb_n = 0; addr_i = 20'h55555;
        step("R7"); chk("R7", "masked proc", AW'(cyc_o), 2);
        chk("R7", "addr kept", addr_o, 20'h12342);

        // reload mid burst
        ce_n = 0; ctrl_strb_n = 0; proc_strb_n = 1; addr_i = 20'h0F0F3; order_il = 0;
        step("R13"); chk("R13", "reload", addr_o, 20'h0F0F3);
        ctrl_strb_n = 1;
        step("R13"); chk("R13", "restart", AW'(addr_o[1:0]), 0);

        // deselect cases
        ce_n = 1; ctrl_strb_n = 0;
        step("R10"); chk("R10", "ctrl ce_n", AW'(cyc_o), 0);
        ctrl_strb_n = 1; ce_n = 0; adv_n = 0;
        step("R12"); chk("R12", "idle stay", AW'(cyc_o), 0);
        proc_strb_n = 0; ce_hi = 0; gw_n = 0;
        step("R10"); chk("R10", "sec low", AW'(cyc_o), 0);
        ce_hi = 1; ce_lo_n = 1; ctrl_strb_n = 0; proc_strb_n = 1;
        step("R10"); chk("R10", "sec high", AW'(cyc_o), 0);
        chk("R10", "no write", AW'(wr_o), 0);

        // constrained random traffic
        void'($urandom(32'h5EED_1234));
        idle_in();
        for (int i = 0; i < 4000; i++) begin
            proc_strb_n = ($urandom % 100) >= 15;
            ctrl_strb_n = ($urandom % 100) >= 15;
            adv_n       = ($urandom % 100) >= 70;
            ce_n        = ($urandom % 100) >= 85;
            ce_hi       = ($urandom % 100) < 90;
            ce_lo_n     = ($urandom % 100) >= 90;
            gw_n        = ($urandom % 100) >= 20;
            bw_n        = $urandom % 2;
            byte_wr_n   = ($urandom % 2) ? '1 : NB'($urandom);
            order_il    = $urandom % 2;
            addr_i      = AW'($urandom);
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13 R14 random");
        end

        done = 1'b1;
        summary();
    end

endmodule